// File: doc/BRIEF.md
# Interleaved Frequency-Multiplying Boost PWM Modulator

This block drives the gates of a single-phase boost rectifier that has two or three turn-off switches. Each carrier period holds one energy-storing pulse. The block hands that pulse to the switches in turn, so the inductor sees a pulse every carrier period while each switch conducts only once every n periods. In the pair modes, n is 2. In the triple mode, n is 3. The carrier is a symmetric up/down counter. Pulses are centred on its peak, so a pulse never straddles the boundary between two periods.

The duty word and the mode select are captured at fixed points of the carrier. The duty word is captured at both the valley and the peak, which gives two updates per period. The mode is captured at the valley only. A sample strobe marks both capture points so that an external control loop can align its measurements with them. Turn-on of every gate is delayed by a programmable dead time. The two main switches share a hard interlock, because turning both on together would short the dc-link. Synchronous reset and a low enable both return the block to a quiet state. The first pulse after either one goes to the first main switch.

Top module: `ripple_mult_pwm`

## Requirements
- R1: The internal carrier counts 0,1,…,PEAK,…,1 and repeats, so one period lasts 2·PEAK clock cycles. `sampleStb` is high, while the block is enabled and out of reset, exactly in the cycles where the count is 0 (valley) or PEAK (peak). That gives two strobes per period.
- R2: `gateOut[0]` (switch 1) and `gateOut[1]` (switch 2) are never high in the same cycle.
- R3: Each gate rises only after its internal command has been high for DEAD+1 cycles, and falls one cycle after the command drops. Between one main gate falling and the other main gate rising there are at least DEAD cycles with both low.
- R4: The duty word is captured only in the valley and peak cycles. With captured duty d, the active switch is commanded in every count c where c+d > PEAK. When d ≥ PEAK, it is commanded for the whole period.
- R5: A captured duty of 0 produces no gate pulse at all.
- R6: Mode 0 (`modeIn`=2'd0, single) gives every pulse to switch 1, and gates 1 and 2 stay low.
- R7: Mode 1 (2'd1, pair) alternates the pulses between switch 1 and switch 2, one per carrier period, and switch 3 stays low.
- R8: Mode 2 (2'd2, pair with auxiliary) alternates like mode 1. Switch 3 is commanded in every cycle in which the active main switch is commanded.
- R9: Mode 3 (2'd3, triple) hands the pulses to switch 1, switch 2 and switch 3 in that order, one per carrier period.
- R10: `modeIn` is captured only at the valley. The next owner is the current owner plus one, wrapped to switch 1 when it reaches the leg count of the newly captured mode. The leg counts are 1, 2, 2 and 3 for modes 0 to 3.
- R11: While `rst` is high or `en` is low, all gates are low and the strobe is low. The carrier restarts at the valley, and the first pulse afterwards goes to switch 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Modulator enable; when low, acts as a reset |
| dutyIn | input | CNT_W | Duty word scaled to PEAK |
| modeIn | input | 2 | Switch-usage mode (0 single, 1 pair, 2 pair+aux, 3 triple) |
| gateOut | output | 3 | Gate commands: bit 0 switch 1, bit 1 switch 2, bit 2 switch 3 |
| sampleStb | output | 1 | Strobe at carrier valley and peak |

## Verification
Several properties are checked on every cycle by assertions. These are the main-switch interlock, the gap between opposing main gates, the carrier staying within its range, duty and mode changing only after their capture points, and gates staying quiet under a zero duty. Other behaviours can only be shown by the bench's scenarios, where a behavioural model is compared on every clock. These are the order of the pulse rotation in each mode, the auxiliary switch following the active main switch, the exact pulse widths under double update, the mode-change wrap rule, and the restart at switch 1 after enable drops.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_PAIR     = 2'd1,
    MODE_PAIR_AUX = 2'd2,
    MODE_TRIPLE   = 2'd3
  } mode_e;

  // Strobes and owner selection passed from control to the gate datapath
  typedef struct packed {
    logic       valley;
    logic       peak;
    logic [2:0] owner;
    logic       auxFollow;
  } pwmx_ctl_t;

  function automatic logic [1:0] legCount(mode_e m);
    case (m)
      MODE_SINGLE:   legCount = 2'd1;
      MODE_PAIR:     legCount = 2'd2;
      MODE_PAIR_AUX: legCount = 2'd2;
      default:       legCount = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/rmp_carrier_ctrl.sv
module rmp_carrier_ctrl
  import pwmx_pkg::*;
#(
  parameter int PEAK  = 40,
  parameter int CNT_W = $clog2(PEAK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       modeIn,
  output logic [CNT_W-1:0] cnt,
  output pwmx_ctl_t        ctl
);

  logic       countUp;
  mode_e      modeQ;
  logic [1:0] slotQ;
  logic       fresh;
  logic       atValley;
  logic       atPeak;
  logic [1:0] slotInc;
  logic [1:0] nextSlot;
  mode_e      modeNew;

  assign atValley = (cnt == '0);
  assign atPeak   = (cnt == CNT_W'(PEAK));
  assign modeNew  = mode_e'(modeIn);
  assign slotInc  = slotQ + 2'd1;
  assign nextSlot = (slotInc >= legCount(modeNew)) ? 2'd0 : slotInc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      countUp <= 1'b1;
      modeQ   <= MODE_SINGLE;
      slotQ   <= 2'd0;
      fresh   <= 1'b1;
    end else begin
      if (countUp) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(PEAK - 1)) countUp <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) countUp <= 1'b1;
      end
      if (atValley) begin
        modeQ <= modeNew;
        fresh <= 1'b0;
        slotQ <= fresh ? 2'd0 : nextSlot;
      end
    end
  end

  always_comb begin
    ctl.valley    = atValley;
    ctl.peak      = atPeak;
    ctl.auxFollow = (modeQ == MODE_PAIR_AUX);
    for (int i = 0; i < 3; i++) ctl.owner[i] = (slotQ == 2'(i));
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(PEAK));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(modeQ) |-> ($past(cnt) == '0) || $past(rst) || !$past(en));

  // R6
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_SINGLE) |-> (slotQ == 2'd0));

endmodule

// File: rtl/rmp_gate_path.sv
module rmp_gate_path
  import pwmx_pkg::*;
#(
  parameter int PEAK  = 40,
  parameter int DEAD  = 4,
  parameter int CNT_W = $clog2(PEAK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [CNT_W-1:0] cnt,
  input  pwmx_ctl_t        ctl,
  output logic [2:0]       gateOut
);

  localparam int DLY_W = (DEAD < 1) ? 1 : $clog2(DEAD + 1);

  logic [CNT_W-1:0] dutyQ;
  logic             pwmOn;
  logic [2:0]       cmdNext;
  logic [2:0]       cmdQ;
  logic [2:0]       gRaw;

  always_ff @(posedge clk) begin
    if (rst || !en) dutyQ <= '0;
    else if (ctl.valley || ctl.peak) dutyQ <= dutyIn;
  end

  assign pwmOn = (dutyQ >= CNT_W'(PEAK)) ||
                 (({1'b0, cnt} + {1'b0, dutyQ}) > (CNT_W + 1)'(PEAK));

  always_comb begin
    cmdNext    = ctl.owner & {3{pwmOn}};
    cmdNext[2] = cmdNext[2] | (ctl.auxFollow & pwmOn);
    // interlock on the main pair at command level
    if (cmdNext[0] && cmdNext[1]) cmdNext[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) cmdQ <= '0;
    else            cmdQ <= cmdNext;
  end

  for (genvar gi = 0; gi < 3; gi++) begin : g_chan
    logic [DLY_W-1:0] dly;
    logic             on;
    always_ff @(posedge clk) begin
      if (rst || !en || !cmdQ[gi]) begin
        dly <= '0;
        on  <= 1'b0;
      end else if (dly == DLY_W'(DEAD)) begin
        on  <= 1'b1;
      end else begin
        dly <= dly + 1'b1;
      end
    end
    assign gRaw[gi] = on;
  end

  assign gateOut[0] = gRaw[0] & ~gRaw[1];
  assign gateOut[1] = gRaw[1] & ~gRaw[0];
  assign gateOut[2] = gRaw[2];

  // R2
  no_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(gateOut[0] && gateOut[1]));

  // R3
  dead_gap_s2_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gateOut[1]) |-> !$past(gateOut[0]));

  // R3
  dead_gap_s1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gateOut[0]) |-> !$past(gateOut[1]));

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dutyQ) |-> $past(ctl.valley || ctl.peak) || $past(rst) || !$past(en));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdQ != 3'b000) |-> ($past(dutyQ) != '0));

endmodule

// File: rtl/ripple_mult_pwm.sv
module ripple_mult_pwm
  import pwmx_pkg::*;
#(
  parameter int PEAK  = 40,
  parameter int DEAD  = 4,
  parameter int CNT_W = $clog2(PEAK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [1:0]       modeIn,
  output logic [2:0]       gateOut,
  output logic             sampleStb
);

  logic [CNT_W-1:0] cnt;
  pwmx_ctl_t        ctl;

  rmp_carrier_ctrl #(.PEAK(PEAK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .modeIn(modeIn), .cnt(cnt), .ctl(ctl)
  );

  rmp_gate_path #(.PEAK(PEAK), .DEAD(DEAD), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rst(rst), .en(en), .dutyIn(dutyIn), .cnt(cnt), .ctl(ctl),
    .gateOut(gateOut)
  );

  assign sampleStb = en & ~rst & (ctl.valley | ctl.peak);

endmodule

// File: tb/ripple_mult_pwm_tb.sv
`timescale 1ns/1ps
module ripple_mult_pwm_tb;

  localparam int PEAK  = 40;
  localparam int DEAD  = 4;
  localparam int CNT_W = $clog2(PEAK + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [CNT_W-1:0] dutyIn = '0;
  logic [1:0]       modeIn = 2'd0;
  logic [2:0]       gateOut;
  logic             sampleStb;

  ripple_mult_pwm #(.PEAK(PEAK), .DEAD(DEAD), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .dutyIn(dutyIn), .modeIn(modeIn),
    .gateOut(gateOut), .sampleStb(sampleStb)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int bothHigh = 0;
  bit done = 0;
  string tag = "R11";

  // behavioural reference state
  int mCnt = 0, mUp = 1, mDuty = 0, mMode = 0, mSlot = 0, mFresh = 1;
  int mCmd[3] = '{0, 0, 0};
  int mDly[3] = '{0, 0, 0};
  int mG[3]   = '{0, 0, 0};

  function automatic int legsOf(int m);
    return (m == 0) ? 1 : (m == 3) ? 3 : 2;
  endfunction

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int on;
    int nc[3];
    if (rst || !en) begin
      mCnt = 0; mUp = 1; mDuty = 0; mMode = 0; mSlot = 0; mFresh = 1;
      for (int i = 0; i < 3; i++) begin mCmd[i] = 0; mDly[i] = 0; mG[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (mCmd[i] == 0) begin mDly[i] = 0; mG[i] = 0; end
        else if (mDly[i] == DEAD) mG[i] = 1;
        else mDly[i]++;
      end
      on = (mDuty >= PEAK) || (mCnt + mDuty > PEAK);
      for (int i = 0; i < 3; i++) nc[i] = 0;
      if (on) begin
        nc[mSlot] = 1;
        if (mMode == 2) nc[2] = 1;
      end
      for (int i = 0; i < 3; i++) mCmd[i] = nc[i];
      if (mCnt == 0 || mCnt == PEAK) mDuty = int'(dutyIn);
      if (mCnt == 0) begin
        mSlot = mFresh ? 0 : ((mSlot + 1 >= legsOf(int'(modeIn))) ? 0 : mSlot + 1);
        mMode = int'(modeIn);
        mFresh = 0;
      end
      if (mUp) begin mCnt++; if (mCnt == PEAK) mUp = 0; end
      else begin mCnt--; if (mCnt == 0) mUp = 1; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int expG;
    int expS;
    if (!done) begin
      cycles++;
      expG = (mG[2] << 2) | ((mG[1] & ~mG[0] & 1) << 1) | (mG[0] & ~mG[1] & 1);
      expS = (en && !rst && (mCnt == 0 || mCnt == PEAK)) ? 1 : 0;
      check({tag, " gates"}, int'(gateOut), expG);
      check({tag, " strobe"}, int'(sampleStb), expS);
      if (gateOut[0] && gateOut[1]) bothHigh++;
      if (cycles > 200000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <= 200000 cycles", cycles);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int cntS;
    int cntP;
    int gap;
    int seenFall;
    step(3);
    // R11: quiet under reset
    check("R11 reset gates", int'(gateOut), 0);
    check("R11 reset strobe", int'(sampleStb), 0);

    rst = 0; en = 1; modeIn = 2'd1; dutyIn = CNT_W'(20);
    tag = "R7"; step(400);

    // R1: two strobes per 2*PEAK cycles
    tag = "R1"; cntS = 0;
    for (int i = 0; i < 2 * PEAK; i++) begin step(1); if (sampleStb) cntS++; end
    check("R1 strobes per period", cntS, 2);

    modeIn = 2'd3; dutyIn = CNT_W'(30); tag = "R9"; step(480);
    modeIn = 2'd2; dutyIn = CNT_W'(25); tag = "R8"; step(400);
    modeIn = 2'd0; dutyIn = CNT_W'(10); tag = "R6"; step(240);

    // R5: zero duty gives no pulse
    dutyIn = '0; tag = "R5"; step(200); cntP = 0;
    for (int i = 0; i < 160; i++) begin step(1); if (gateOut != 3'b000) cntP++; end
    check("R5 pulses at zero duty", cntP, 0);

    // R4 / R3: full-scale duty, measure main-pair gap
    modeIn = 2'd1; dutyIn = CNT_W'(PEAK); tag = "R4"; step(200);
    tag = "R3"; gap = 0; seenFall = 0;
    for (int i = 0; i < 400; i++) begin
      step(1);
      if (gateOut[1:0] == 2'b00) gap++;
      else begin
        if (seenFall && gap > 0) check("R3 main-pair gap", (gap >= DEAD) ? 1 : 0, 1);
        seenFall = 1; gap = 0;
      end
    end
    dutyIn = CNT_W'(60); tag = "R4"; step(200);

    // R10 / R4: asynchronous-looking duty and mode changes
    tag = "R10";
    for (int i = 0; i < 120; i++) begin
      dutyIn = CNT_W'($urandom_range(0, 45));
      if ($urandom_range(0, 3) == 0) modeIn = 2'($urandom_range(0, 3));
      step($urandom_range(1, 30));
    end

    // R11: enable drop and restart at switch 1
    tag = "R11"; en = 0; step(20);
    check("R11 disabled gates", int'(gateOut), 0);
    modeIn = 2'd3; dutyIn = CNT_W'(30); en = 1;
    for (int i = 0; i < 200 && gateOut == 3'b000; i++) step(1);
    check("R11 first owner after enable", int'(gateOut), 1);
    step(400);
    rst = 1; step(2); rst = 0; step(300);

    check("R2 overlap cycles", bothHigh, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule